// File: doc/BRIEF.md
# Bus Cycle Controller with Backoff Replay

This block sits between a processor core and an external shared bus and runs the core's memory and I/O cycles on that bus. The core offers a cycle through a valid/ready handshake, giving the address, byte enables, the kind of cycle and, for writes, up to four beats of write data. The controller latches that descriptor and drives a one-clock address strobe. It then counts data beats on a per-transfer ready input: one beat for a single cycle, `BURST_LEN` beats for a burst. When the last beat is accepted it pulses a completion strobe, and for reads it presents all collected beats.

A backoff input lets another master take the bus at any moment. On each rising edge where backoff is high, the controller drops its output enables and abandons whatever cycle it was running, even if a ready arrives on the same edge. On the first edge where backoff is low again, it reissues the abandoned cycle from its first beat, using the latched descriptor. Read beats gathered before the abort are never reported. Backoff governs the output enables even while reset or init is held.

Top module: `bus_cycle_ctl`

## Requirements
- R1: After an accepted request the controller drives `bus_ads` high for exactly one clock and then counts beats on edges where `bus_rdy` is high. A single cycle (`req_burst`=0) takes 1 beat and a burst takes `BURST_LEN` beats. `bus_rdy` on the edge that ends the strobe clock is not counted.
- R2: `cmp_valid` pulses high for one clock, in the clock after the edge that accepts the final beat. For a read, `cmp_rdata` then holds beat i in bits [i*DATA_W +: DATA_W].
- R3: In the clock after every edge where `backoff` is sampled high, `bus_oe` is low. In the clock after every edge where it is sampled low, `bus_oe` is high.
- R4: A high `backoff` aborts a cycle in either its strobe clock or its data phase. `bus_ads` is never high while `bus_oe` is low.
- R5: If a cycle was aborted, the first edge where `backoff` is sampled low is followed by one clock of `bus_ads`, with the same address, byte enables and cycle kind as the original. The beat count restarts at zero.
- R6: When `backoff` and `bus_rdy` are both high on the same edge, the beat is not accepted and no completion follows from that edge.
- R7: While `rst` or `init` is high, `bus_oe` still follows R3.
- R8: If no cycle was active when backoff was raised, its release returns the controller to idle and no `bus_ads` is driven.
- R9: `req_ready` is high only when the controller is idle and `backoff`, `rst` and `init` are all low. The descriptor is captured on the edge where `req_valid` and `req_ready` are both high.
- R10: Read beats accepted before an abort are discarded. Exactly one completion follows each request, and it comes after the replayed cycle's final beat.
- R11: During the data phase of a write, `bus_dout` carries write beat k (bits [k*DATA_W +: DATA_W] of `req_wdata`) while beat k is pending, and `bus_doe` is high. `bus_doe` is never high unless `bus_oe` is high and the cycle is a write. Replays reproduce the same beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Synchronous soft initialisation; abandons any cycle |
| backoff | input | 1 | Another master wants the bus; active high |
| req_valid | input | 1 | Core offers a cycle |
| req_ready | output | 1 | Controller accepts the offered cycle this edge |
| req_addr | input | ADDR_W | Cycle address |
| req_be | input | DATA_W/8 | Byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_is_data | input | 1 | 1 = data access, 0 = code fetch |
| req_lock | input | 1 | Locked cycle attribute |
| req_cacheable | input | 1 | Cacheable attribute |
| req_burst | input | 1 | 1 = burst of BURST_LEN beats |
| req_wdata | input | BURST_LEN*DATA_W | Write beats, beat 0 in the low slice |
| cmp_valid | output | 1 | One-clock completion pulse |
| cmp_rdata | output | BURST_LEN*DATA_W | Read beats of the completed cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_be | output | DATA_W/8 | Bus byte enables |
| bus_ads | output | 1 | Address strobe |
| bus_write | output | 1 | Write/read indication |
| bus_mem | output | 1 | Memory/I/O indication |
| bus_is_data | output | 1 | Data/code indication |
| bus_lock | output | 1 | Lock attribute |
| bus_cacheable | output | 1 | Cache attribute |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_din | input | DATA_W | Read data from the bus |
| bus_rdy | input | 1 | Per-transfer ready |
| bus_oe | output | 1 | Enable for address, strobe and attribute drivers |
| bus_doe | output | 1 | Enable for write data drivers |

## Verification
The bench uses the default parameters: 32-bit address, 64-bit data and four-beat bursts. With four beats, backoff can be placed on the strobe clock and on each of the beat positions 0 to 3, both with and without a coincident ready. Replays can therefore be compared against the original cycle at every point where an abort can land. The 64-bit data width lets each beat pattern encode the address and the beat index, so a miscounted or stale beat shows up in the completion data.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    // Bus sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } bcc_state_e;

    // Attributes of one bus cycle, latched with the descriptor
    typedef struct packed {
        logic write;
        logic mem;
        logic is_data;
        logic lock;
        logic cacheable;
        logic burst;
    } bcc_kind_t;

    // Index of the final beat of a cycle
    function automatic int unsigned last_beat(input logic burst, input int unsigned blen);
        return burst ? blen - 1 : 0;
    endfunction

endpackage

// File: rtl/bcc_desc_latch.sv
module bcc_desc_latch
    import bcc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [ADDR_W-1:0]             addr_in,
    input  logic [DATA_W/8-1:0]           be_in,
    input  bcc_kind_t                     kind_in,
    input  logic [BURST_LEN*DATA_W-1:0]   wdata_in,
    input  logic [$clog2(BURST_LEN)-1:0]  beat_sel,
    output logic [ADDR_W-1:0]             addr_q,
    output logic [DATA_W/8-1:0]           be_q,
    output bcc_kind_t                     kind_q,
    output logic [DATA_W-1:0]             wbeat
);
    logic [DATA_W-1:0] wbeat_q [BURST_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            be_q   <= '0;
            kind_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            be_q   <= be_in;
            kind_q <= kind_in;
        end
    end

    // One register per write beat so a replay reproduces every beat
    for (genvar gi = 0; gi < BURST_LEN; gi++) begin : g_wbeat
        always_ff @(posedge clk) begin
            if (rst)       wbeat_q[gi] <= '0;
            else if (load) wbeat_q[gi] <= wdata_in[gi*DATA_W +: DATA_W];
        end
    end

    assign wbeat = wbeat_q[beat_sel];

endmodule

// File: rtl/bcc_sequencer.sv
module bcc_sequencer
    import bcc_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          init,
    input  logic                          backoff,
    input  logic                          req_valid,
    input  logic                          rdy,
    input  logic                          burst,
    output bcc_state_e                    st,
    output logic                          pend,
    output logic [$clog2(BURST_LEN)-1:0]  beat,
    output logic                          grant,
    output logic                          take,
    output logic                          done
);
    localparam int BEAT_W = $clog2(BURST_LEN);

    logic quiet;
    logic final_beat;

    assign quiet      = !backoff && !rst && !init;
    assign grant      = (st == ST_IDLE) && quiet;
    assign take       = (st == ST_DATA) && rdy && quiet;
    assign final_beat = (beat == BEAT_W'(last_beat(burst, BURST_LEN)));

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || init) begin
            st   <= ST_IDLE;
            pend <= 1'b0;
            beat <= '0;
        end else if (backoff) begin
            // Backoff outranks everything, including a same-edge ready
            st   <= ST_HOLD;
            beat <= '0;
            if (st != ST_HOLD) pend <= (st != ST_IDLE);
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) st <= ST_ADDR;
                ST_ADDR: st <= ST_DATA;
                ST_DATA: if (rdy) begin
                    if (final_beat) begin
                        st   <= ST_IDLE;
                        beat <= '0;
                        done <= 1'b1;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                ST_HOLD: begin
                    st   <= pend ? ST_ADDR : ST_IDLE;
                    pend <= 1'b0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bcc_read_collect.sv
module bcc_read_collect #(
    parameter int DATA_W    = 64,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          take,
    input  logic                          is_read,
    input  logic [$clog2(BURST_LEN)-1:0]  beat,
    input  logic [DATA_W-1:0]             din,
    output logic [BURST_LEN*DATA_W-1:0]   rdata
);
    // Each slot is rewritten by the replay, so beats from an aborted
    // attempt never reach the completion
    for (genvar gi = 0; gi < BURST_LEN; gi++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (take && is_read && (beat == ($clog2(BURST_LEN))'(gi)))
                slot_q <= din;
        end
        assign rdata[gi*DATA_W +: DATA_W] = slot_q;
    end

endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl
    import bcc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          init,
    input  logic                          backoff,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W/8-1:0]           req_be,
    input  logic                          req_write,
    input  logic                          req_mem,
    input  logic                          req_is_data,
    input  logic                          req_lock,
    input  logic                          req_cacheable,
    input  logic                          req_burst,
    input  logic [BURST_LEN*DATA_W-1:0]   req_wdata,
    output logic                          cmp_valid,
    output logic [BURST_LEN*DATA_W-1:0]   cmp_rdata,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic [DATA_W/8-1:0]           bus_be,
    output logic                          bus_ads,
    output logic                          bus_write,
    output logic                          bus_mem,
    output logic                          bus_is_data,
    output logic                          bus_lock,
    output logic                          bus_cacheable,
    output logic [DATA_W-1:0]             bus_dout,
    input  logic [DATA_W-1:0]             bus_din,
    input  logic                          bus_rdy,
    output logic                          bus_oe,
    output logic                          bus_doe
);
    localparam int BEAT_W = $clog2(BURST_LEN);

    bcc_state_e         st;
    logic               pend;
    logic [BEAT_W-1:0]  beat;
    logic               grant;
    logic               take;
    logic               oe_q;
    bcc_kind_t          kind_in;
    bcc_kind_t          kind_q;

    assign kind_in = '{write:     req_write,
                       mem:       req_mem,
                       is_data:   req_is_data,
                       lock:      req_lock,
                       cacheable: req_cacheable,
                       burst:     req_burst};

    bcc_sequencer #(.BURST_LEN(BURST_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .init      (init),
        .backoff   (backoff),
        .req_valid (req_valid),
        .rdy       (bus_rdy),
        .burst     (kind_q.burst),
        .st        (st),
        .pend      (pend),
        .beat      (beat),
        .grant     (grant),
        .take      (take),
        .done      (cmp_valid)
    );

    bcc_desc_latch #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BURST_LEN (BURST_LEN)
    ) u_desc (
        .clk      (clk),
        .rst      (rst),
        .load     (grant && req_valid),
        .addr_in  (req_addr),
        .be_in    (req_be),
        .kind_in  (kind_in),
        .wdata_in (req_wdata),
        .beat_sel (beat),
        .addr_q   (bus_addr),
        .be_q     (bus_be),
        .kind_q   (kind_q),
        .wbeat    (bus_dout)
    );

    bcc_read_collect #(
        .DATA_W    (DATA_W),
        .BURST_LEN (BURST_LEN)
    ) u_rd (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .is_read (!kind_q.write),
        .beat    (beat),
        .din     (bus_din),
        .rdata   (cmp_rdata)
    );

    // Output enable tracks the sampled backoff on every edge; reset and
    // init deliberately do not gate it
    always_ff @(posedge clk) begin
        oe_q <= !backoff;
    end

    assign req_ready     = grant;
    assign bus_oe        = oe_q;
    assign bus_ads       = (st == ST_ADDR);
    assign bus_doe       = oe_q && (st == ST_DATA) && kind_q.write;
    assign bus_write     = kind_q.write;
    assign bus_mem       = kind_q.mem;
    assign bus_is_data   = kind_q.is_data;
    assign bus_lock      = kind_q.lock;
    assign bus_cacheable = kind_q.cacheable;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
    import bcc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       init,
    input logic       backoff,
    input logic       req_ready,
    input logic       bus_ads,
    input logic       bus_oe,
    input logic       bus_doe,
    input logic       bus_write,
    input logic       cmp_valid,
    input bcc_state_e st,
    input logic       pend
);
    p_float_r3: assert property (@(posedge clk) disable iff (rst)
        backoff |=> !bus_oe);

    p_drive_r3: assert property (@(posedge clk) disable iff (rst)
        !backoff |=> bus_oe);

    p_ads_oe_r4: assert property (@(posedge clk) disable iff (rst)
        bus_ads |-> bus_oe);

    p_no_done_r6: assert property (@(posedge clk) disable iff (rst)
        backoff |=> !cmp_valid);

    p_replay_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && pend && !backoff && !init) |=> bus_ads);

    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !pend && !backoff) |=> !bus_ads);

    p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> !cmp_valid);

    p_doe_r11: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (bus_oe && bus_write));

    p_grant_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!backoff && !init));

endmodule

bind bus_cycle_ctl bcc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .backoff   (backoff),
    .req_ready (req_ready),
    .bus_ads   (bus_ads),
    .bus_oe    (bus_oe),
    .bus_doe   (bus_doe),
    .bus_write (bus_write),
    .cmp_valid (cmp_valid),
    .st        (st),
    .pend      (pend)
);

// File: tb/sim_bus_cycle_ctl.sv
module sim_bus_cycle_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int BL = 4;

    typedef struct {
        logic [AW-1:0]   addr;
        logic [DW/8-1:0] be;
        logic            wr;
        logic            burst;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init = 1'b0;
    logic backoff = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW/8-1:0] req_be = '0;
    logic req_write = 1'b0, req_mem = 1'b1, req_is_data = 1'b1;
    logic req_lock = 1'b0, req_cacheable = 1'b0, req_burst = 1'b0;
    logic [BL*DW-1:0] req_wdata = '0;
    logic cmp_valid;
    logic [BL*DW-1:0] cmp_rdata;
    logic [AW-1:0] bus_addr;
    logic [DW/8-1:0] bus_be;
    logic bus_ads, bus_write, bus_mem, bus_is_data, bus_lock, bus_cacheable;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;
    logic bus_rdy = 1'b0;
    logic bus_oe, bus_doe;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_ctl u0 (
        .clk(clk), .rst(rst), .init(init), .backoff(backoff),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_be(req_be), .req_write(req_write), .req_mem(req_mem),
        .req_is_data(req_is_data), .req_lock(req_lock),
        .req_cacheable(req_cacheable), .req_burst(req_burst),
        .req_wdata(req_wdata), .cmp_valid(cmp_valid), .cmp_rdata(cmp_rdata),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_ads(bus_ads),
        .bus_write(bus_write), .bus_mem(bus_mem), .bus_is_data(bus_is_data),
        .bus_lock(bus_lock), .bus_cacheable(bus_cacheable),
        .bus_dout(bus_dout), .bus_din(bus_din), .bus_rdy(bus_rdy),
        .bus_oe(bus_oe), .bus_doe(bus_doe)
    );

    int vecs = 0;
    int bad = 0;

    exp_t sbq[$];
    exp_t cur;
    bit   cur_act = 0;

    // bus model configuration: inj_beat -1 none, -2 on the strobe clock
    int inj_beat = -1;
    bit inj_rdy = 0;
    bit rdy_always = 0;
    bit force_bk = 0;
    bit injected = 0;
    int ads_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rpat(input logic [AW-1:0] a, input int b);
        return {a, 24'h5A5A00, 8'(b)};
    endfunction

    function automatic logic [DW-1:0] wpat(input logic [AW-1:0] a, input int b);
        return {~a, 24'hC3C300, 8'(b)};
    endfunction

    // Bus responder: samples outputs at the falling edge, drives the next edge
    initial begin
        int  mbeat = 0;
        bit  in_data = 0;
        int  bk_cnt = 0;
        logic rdy_n;
        logic [DW-1:0] din_n;
        forever begin
            @(negedge clk);
            chk(bus_oe == !backoff, "R3", "oe vs sampled backoff", 64'(bus_oe), 64'(!backoff));
            if (backoff) chk(!bus_ads, "R4", "strobe while floated", 64'(bus_ads), 64'd0);
            rdy_n = 1'b0;
            din_n = '0;
            if (bk_cnt > 0) bk_cnt--;
            if (bus_ads) begin
                if (!cur_act) begin
                    chk(1'b0, "R8", "strobe with no cycle", 64'd1, 64'd0);
                end else begin
                    chk(bus_addr == cur.addr, "R5", "strobe address", 64'(bus_addr), 64'(cur.addr));
                    chk(bus_be == cur.be && bus_write == cur.wr, "R5", "strobe be/kind",
                        {bus_be, 7'd0, bus_write}, {cur.be, 7'd0, cur.wr});
                end
                ads_cnt++;
                in_data = 1;
                mbeat = 0;
                rdy_n = rdy_always;
                if (inj_beat == -2 && !injected) begin
                    injected = 1;
                    bk_cnt = 3;
                    in_data = 0;
                end
            end else if (in_data && bk_cnt == 0) begin
                din_n = rpat(cur.addr, mbeat);
                if (cur.wr)
                    chk(bus_doe && bus_dout == wpat(cur.addr, mbeat), "R11", "write beat",
                        bus_dout, wpat(cur.addr, mbeat));
                if (inj_beat == mbeat && !injected) begin
                    injected = 1;
                    bk_cnt = 3;
                    in_data = 0;
                    rdy_n = inj_rdy;
                end else begin
                    rdy_n = 1'b1;
                    mbeat++;
                    if (mbeat == (cur.burst ? BL : 1)) in_data = 0;
                end
            end
            backoff = force_bk || (bk_cnt > 0);
            bus_rdy = rdy_n;
            bus_din = din_n;
        end
    end

    // Scoreboard monitor: pops one expected item per completion
    initial begin
        forever begin
            @(negedge clk);
            if (cmp_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R10", "completion without request", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(ads_cnt == (injected ? 2 : 1), "R10", "strobes before completion",
                        64'(ads_cnt), 64'(injected ? 2 : 1));
                    if (!e.wr)
                        for (int i = 0; i < (e.burst ? BL : 1); i++)
                            chk(cmp_rdata[i*DW +: DW] == rpat(e.addr, i), "R2", "read beat",
                                cmp_rdata[i*DW +: DW], rpat(e.addr, i));
                    cur_act = 0;
                end
            end
        end
    end

    task automatic issue(input logic [AW-1:0] a, input logic [DW/8-1:0] be,
                         input bit wr, input bit burst,
                         input int ib, input bit ir, input bit ra);
        exp_t e;
        int waitc;
        @(negedge clk);
        e.addr = a; e.be = be; e.wr = wr; e.burst = burst;
        cur = e;
        cur_act = 1;
        inj_beat = ib; inj_rdy = ir; rdy_always = ra;
        injected = 0; ads_cnt = 0;
        sbq.push_back(e);
        req_addr = a; req_be = be; req_write = wr; req_burst = burst;
        req_cacheable = burst;
        for (int i = 0; i < BL; i++) req_wdata[i*DW +: DW] = wpat(a, i);
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R9", "ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = '0;
        req_addr = '0;
        waitc = 0;
        while (sbq.size() != 0 && waitc < 200) begin
            @(negedge clk);
            waitc++;
        end
        chk(sbq.size() == 0, "R1", "cycle completed", 64'(sbq.size()), 64'd0);
        if (ib != -1) chk(injected, "R5", "abort was injected", 64'(injected), 64'd1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        bad++;
        vecs++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        // R7: backoff honoured during reset
        force_bk = 1;
        repeat (3) @(negedge clk);
        chk(bus_oe == 1'b0, "R7", "oe in reset with backoff", 64'(bus_oe), 64'd0);
        chk(req_ready == 1'b0 && !bus_ads && !cmp_valid, "R9", "quiet in reset",
            {req_ready, bus_ads, cmp_valid}, 64'd0);
        force_bk = 0;
        repeat (2) @(negedge clk);
        chk(bus_oe == 1'b1, "R7", "oe in reset after release", 64'(bus_oe), 64'd1);
        rst = 0;
        init = 1;
        force_bk = 1;
        repeat (2) @(negedge clk);
        chk(bus_oe == 1'b0 && !req_ready, "R7", "oe/ready in init with backoff",
            {bus_oe, req_ready}, 64'd0);
        force_bk = 0;
        init = 0;
        repeat (2) @(negedge clk);

        // R1: plain cycles
        issue(32'h0000_1000, 8'hFF, 0, 0, -1, 0, 0);
        issue(32'h0000_2008, 8'h0F, 1, 0, -1, 0, 0);
        issue(32'h0000_3020, 8'hFF, 0, 1, -1, 0, 1);  // R1 ready on strobe edge ignored
        issue(32'h0000_4040, 8'hFF, 1, 1, -1, 0, 0);

        // R4 R5 R6 R10: backoff at every beat, with and without ready
        for (int b = 0; b < BL; b++) begin
            issue(32'h0001_0000 + 32'(b * 32), 8'hFF, 0, 1, b, 0, 0);
            issue(32'h0002_0000 + 32'(b * 32), 8'hFF, 0, 1, b, 1, 0);  // R6
            issue(32'h0003_0000 + 32'(b * 32), 8'hF0, 1, 1, b, 1, 0);  // R11 replayed writes
        end
        issue(32'h0004_0000, 8'hFF, 1, 1, -2, 0, 0);   // R4 abort in strobe clock
        issue(32'h0004_1000, 8'h3C, 0, 0, 0, 1, 0);    // R6 single read

        // R8: backoff with no cycle active
        @(negedge clk);
        force_bk = 1;
        @(negedge clk);
        #1;
        chk(req_ready == 1'b0, "R9", "no grant under backoff", 64'(req_ready), 64'd0);
        repeat (2) @(negedge clk);
        force_bk = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!bus_ads, "R8", "no strobe after idle release", 64'(bus_ads), 64'd0);
        end
        #1;
        chk(req_ready == 1'b1, "R8", "idle after release", 64'(req_ready), 64'd1);

        issue(32'h0005_0000, 8'hFF, 0, 1, 2, 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule